// File: doc/BRIEF.md
# Byte DMA Engine with Processor-Halt Bus Handover

This block moves single bytes between a shared memory bus and a peripheral data port, one byte per peripheral request. Firmware supplies a 16-bit start address, a 16-bit byte count and a direction, then pulses a start strobe. The engine asks the host processor to go idle. It does not drive the memory bus until the processor reports that it has halted.

While it owns the bus, the engine services each peripheral request. In send direction it reads a byte from memory and hands it to the peripheral. In receive direction it takes a byte from the peripheral and stores it in memory. After every byte the address pointer advances, carrying from its low byte into its high byte, and the count drops by one. When the count reaches zero the engine finishes. An interrupt that is enabled in the mask ends the transfer early and leaves the pointer and count at their partial values. Two separate status flags tell normal completion apart from an interrupt abort.

Top module: `byte_dma`

## Requirements
- R1: While rst_n is low and in the first cycle after it, busy, idle_req, bus_own, mem_rd, mem_wr, per_ack, done_flag and abort_flag are all 0.
- R2: A cfg_start pulse in idle with a nonzero cfg_len loads cur_addr and cur_len, and raises busy and idle_req from the next cycle. bus_own stays 0 while cpu_halted is low.
- R3: bus_own rises only in the cycle after cpu_halted was sampled high. mem_rd and mem_wr are never asserted while bus_own is low.
- R4: Send direction (cfg_dir = 1): a sampled per_req leads to a one-cycle mem_rd at cur_addr in the next cycle. Two cycles after that read, per_ack is high for one cycle and per_wdata carries the byte read.
- R5: Receive direction (cfg_dir = 0): a sampled per_req leads to one cycle in which mem_wr and per_ack are both high, mem_addr equals cur_addr and mem_wdata equals per_rdata.
- R6: Each byte moved increments cur_addr by one across all 16 bits (0x00FF becomes 0x0100, 0xFFFF becomes 0x0000) and decrements cur_len by one.
- R7: When the byte that brings cur_len to zero is moved, busy, idle_req and bus_own fall and done_flag rises on the same clock edge.
- R8: A start with cfg_len = 0 sets done_flag on the next cycle and never raises idle_req, busy or any memory or peripheral strobe.
- R9: An interrupt counts as unmasked when (irq_pend & irq_en) is nonzero, with each irq_en bit set to 1 enabling its source. If such an interrupt is seen while the engine waits for the halt or for a request, the engine drops busy, idle_req and bus_own on the next edge and sets abort_flag. cur_addr and cur_len keep their values. Pending interrupts whose enable bits are 0 have no effect.
- R10: per_ack is high for exactly one cycle per byte. No byte moves, and cur_len does not change, while per_req stays low.
- R11: cfg_start while busy is high is ignored: cur_addr, cur_len and the transfer in progress are unchanged.
- R12: An accepted start clears both done_flag and abort_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start strobe, one cycle |
| cfg_dir | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| cfg_addr | input | 16 | Start address |
| cfg_len | input | 16 | Byte count |
| irq_pend | input | 8 | Pending interrupt lines |
| irq_en | input | 8 | Interrupt enables, 1 = unmasked |
| cpu_halted | input | 1 | Processor reports it is halted |
| idle_req | output | 1 | Request for the processor to enter idle |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Last transfer completed normally |
| abort_flag | output | 1 | Last transfer ended by interrupt |
| cur_addr | output | 16 | Current address pointer |
| cur_len | output | 16 | Remaining byte count |
| bus_own | output | 1 | Engine drives the memory bus |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| per_req | input | 1 | Peripheral requests a byte transfer |
| per_ack | output | 1 | One-cycle acknowledge per byte |
| per_wdata | output | 8 | Byte to peripheral |
| per_rdata | input | 8 | Byte from peripheral |

## Verification
The properties assume three things about the block's inputs. Memory returns read data in the cycle after mem_rd. The peripheral drops per_req in the cycle after it sees per_ack. cpu_halted stays high while idle_req is high and bus_own is set. The bench keeps to these assumptions. Its peripheral task lowers the request on the same falling edge at which it observes the acknowledge. Its memory model registers read data on the strobe edge. It raises cpu_halted only after it sees idle_req, and lowers it only after the engine has released the bus. Interrupt lines change only between bytes, while the engine waits for a request.

// File: rtl/byte_dma_pkg.sv
package byte_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HALT = 3'd1,
    ST_WREQ = 3'd2,
    ST_RD   = 3'd3,
    ST_CAP  = 3'd4,
    ST_ACK  = 3'd5,
    ST_WR   = 3'd6
  } dma_st_e;

  typedef enum logic {
    DIR_RECV = 1'b0,
    DIR_SEND = 1'b1
  } dma_dir_e;

endpackage

// File: rtl/dma_irq_gate.sv
module dma_irq_gate #(
  parameter int IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] en,
  output logic             hit
);

  logic [IRQ_W-1:0] live;

  always_comb begin
    live = pend & en;
    hit  = |live;
  end

endmodule

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              last_byte
);

  localparam int LANES = ADDR_W / LANE_W;

  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] addr_d;
  logic [LEN_W-1:0]  len_d;
  logic              ptr_en;

  // byte-lane incrementer: a lane steps when all lower bits are ones
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign addr_inc[LANE_W-1:0] = addr_q[LANE_W-1:0] + LANE_W'(1);
    end else begin : g_up
      logic cin;
      assign cin = &addr_q[g*LANE_W-1:0];
      assign addr_inc[g*LANE_W +: LANE_W] =
        addr_q[g*LANE_W +: LANE_W] + {{(LANE_W-1){1'b0}}, cin};
    end
  end

  always_comb begin
    ptr_en = load | step;
    addr_d = addr_q;
    len_d  = len_q;
    if (load) begin
      addr_d = ld_addr;
      len_d  = ld_len;
    end else if (step) begin
      addr_d = addr_inc;
      len_d  = len_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (ptr_en) begin
      addr_q <= addr_d;
      len_q  <= len_d;
    end
  end

  assign last_byte = (len_q == LEN_W'(1));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import byte_dma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dma_dir_e          dir_in,
  input  logic              len_zero,
  input  logic              irq_hit,
  input  logic              cpu_halted,
  input  logic              per_req,
  input  logic              last_byte,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load,
  output logic              step,
  output logic              busy,
  output logic              idle_req,
  output logic              bus_own,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_wdata,
  output logic              done_flag,
  output logic              abort_flag
);

  dma_st_e          st_q, st_d;
  dma_dir_e         dir_q;
  logic [DATA_W-1:0] data_q;
  logic             set_done, set_abort, clr_flags;
  logic             done_en, abort_en, data_en;

  always_comb begin
    st_d      = st_q;
    load      = 1'b0;
    step      = 1'b0;
    set_done  = 1'b0;
    set_abort = 1'b0;
    clr_flags = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          load      = 1'b1;
          clr_flags = 1'b1;
          if (len_zero) set_done = 1'b1;
          else          st_d     = ST_HALT;
        end
      end
      ST_HALT: begin
        if (irq_hit) begin
          st_d      = ST_IDLE;
          set_abort = 1'b1;
        end else if (cpu_halted) begin
          st_d = ST_WREQ;
        end
      end
      ST_WREQ: begin
        if (irq_hit) begin
          st_d      = ST_IDLE;
          set_abort = 1'b1;
        end else if (per_req) begin
          st_d = (dir_q == DIR_SEND) ? ST_RD : ST_WR;
        end
      end
      ST_RD:  st_d = ST_CAP;
      ST_CAP: st_d = ST_ACK;
      ST_ACK, ST_WR: begin
        step = 1'b1;
        if (last_byte) begin
          st_d     = ST_IDLE;
          set_done = 1'b1;
        end else begin
          st_d = ST_WREQ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_en  = clr_flags | set_done;
    abort_en = clr_flags | set_abort;
    data_en  = (st_q == ST_CAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir_q <= DIR_RECV;
    else if (load) dir_q <= dir_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_flag <= 1'b0;
    else if (done_en) done_flag <= set_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        abort_flag <= 1'b0;
    else if (abort_en) abort_flag <= set_abort;
  end

  always_comb begin
    busy      = (st_q != ST_IDLE);
    idle_req  = busy;
    bus_own   = (st_q == ST_WREQ) || (st_q == ST_RD) || (st_q == ST_CAP) ||
                (st_q == ST_ACK)  || (st_q == ST_WR);
    mem_rd    = (st_q == ST_RD);
    mem_wr    = (st_q == ST_WR);
    per_ack   = (st_q == ST_ACK) || (st_q == ST_WR);
    per_wdata = (st_q == ST_ACK) ? data_q : '0;
  end

endmodule

// File: rtl/byte_dma.sv
module byte_dma
  import byte_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8,
  parameter int IRQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              cfg_dir,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [IRQ_W-1:0]  irq_pend,
  input  logic [IRQ_W-1:0]  irq_en,
  input  logic              cpu_halted,
  output logic              idle_req,
  output logic              busy,
  output logic              done_flag,
  output logic              abort_flag,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_len,
  output logic              bus_own,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata
);

  logic irq_hit, load, step, last_byte, len_zero;

  assign len_zero = (cfg_len == '0);

  dma_irq_gate #(.IRQ_W(IRQ_W)) u_irq (
    .pend (irq_pend),
    .en   (irq_en),
    .hit  (irq_hit)
  );

  dma_ptr_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANE_W(DATA_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .ld_addr   (cfg_addr),
    .ld_len    (cfg_len),
    .addr_q    (cur_addr),
    .len_q     (cur_len),
    .last_byte (last_byte)
  );

  dma_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cfg_start),
    .dir_in     (dma_dir_e'(cfg_dir)),
    .len_zero   (len_zero),
    .irq_hit    (irq_hit),
    .cpu_halted (cpu_halted),
    .per_req    (per_req),
    .last_byte  (last_byte),
    .mem_rdata  (mem_rdata),
    .load       (load),
    .step       (step),
    .busy       (busy),
    .idle_req   (idle_req),
    .bus_own    (bus_own),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .per_ack    (per_ack),
    .per_wdata  (per_wdata),
    .done_flag  (done_flag),
    .abort_flag (abort_flag)
  );

  assign mem_addr  = bus_own ? cur_addr  : '0;
  assign mem_wdata = mem_wr  ? per_rdata : '0;

endmodule

// File: rtl/byte_dma_chk.sv
module byte_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_start,
  input logic              cpu_halted,
  input logic              idle_req,
  input logic              busy,
  input logic              done_flag,
  input logic              abort_flag,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LEN_W-1:0]  cur_len,
  input logic              bus_own,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] per_rdata,
  input logic              per_ack
);

  // R2
  idle_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_req) |-> $past(cfg_start));

  // R3
  own_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(cpu_halted));

  // R3
  strobe_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_own);

  // R4
  read_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 per_ack);

  // R5
  recv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (per_ack && mem_addr == cur_addr && mem_wdata == per_rdata));

  // R6
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> (cur_len == $past(cur_len) - LEN_W'(1)));

  // R7
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!idle_req && !bus_own && (done_flag ^ abort_flag)));

  // R9
  abort_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_flag) |-> ($stable(cur_addr) && $stable(cur_len)));

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

endmodule

bind byte_dma byte_dma_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_start  (cfg_start),
  .cpu_halted (cpu_halted),
  .idle_req   (idle_req),
  .busy       (busy),
  .done_flag  (done_flag),
  .abort_flag (abort_flag),
  .cur_addr   (cur_addr),
  .cur_len    (cur_len),
  .bus_own    (bus_own),
  .mem_addr   (mem_addr),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_wdata  (mem_wdata),
  .per_rdata  (per_rdata),
  .per_ack    (per_ack)
);

// File: tb/byte_dma_tb.sv
module byte_dma_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_start, cfg_dir;
  logic [15:0] cfg_addr, cfg_len;
  logic [7:0]  irq_pend, irq_en;
  logic        cpu_halted;
  logic        idle_req, busy, done_flag, abort_flag, bus_own;
  logic [15:0] cur_addr, cur_len, mem_addr;
  logic        mem_rd, mem_wr, per_req, per_ack;
  logic [7:0]  mem_wdata, mem_rdata, per_wdata, per_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  int n_cyc  = 0;
  int n_ack  = 0;
  int n_strb = 0;
  int n_bad  = 0;
  logic [7:0] mem [0:255];

  byte_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_dir(cfg_dir),
    .cfg_addr(cfg_addr), .cfg_len(cfg_len), .irq_pend(irq_pend), .irq_en(irq_en),
    .cpu_halted(cpu_halted), .idle_req(idle_req), .busy(busy),
    .done_flag(done_flag), .abort_flag(abort_flag), .cur_addr(cur_addr),
    .cur_len(cur_len), .bus_own(bus_own), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata),
    .per_rdata(per_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model: read data returns the cycle after the strobe
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // monitor and watchdog
  always @(negedge clk) begin
    n_cyc++;
    if (per_ack) n_ack++;
    if (mem_rd || mem_wr) n_strb++;
    if ((mem_rd || mem_wr) && !bus_own) n_bad++;
    if (n_cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 50000", n_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic start_xfer(input logic dir, input logic [15:0] a, input logic [15:0] l);
    @(negedge clk);
    cfg_dir = dir; cfg_addr = a; cfg_len = l; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic grant();
    chk("R2 idle_req after start", idle_req, 1);
    chk("R2 busy after start", busy, 1);
    @(negedge clk);
    chk("R2 no bus before halt", bus_own, 0);
    cpu_halted = 1'b1;
    @(negedge clk);
    chk("R3 bus after halt", bus_own, 1);
  endtask

  task automatic do_byte(input logic [7:0] rx, output logic [7:0] got);
    per_rdata = rx;
    per_req   = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (per_ack) break;
    end
    got     = per_wdata;
    per_req = 1'b0;
    chk("R10 ack seen", per_ack, 1);
    @(negedge clk);
    chk("R10 ack one cycle", per_ack, 0);
  endtask

  task automatic finish_chk(input logic [15:0] ea);
    chk("R7 busy low", busy, 0);
    chk("R7 idle_req low", idle_req, 0);
    chk("R7 bus released", bus_own, 0);
    chk("R7 done set", done_flag, 1);
    chk("R6 final addr", cur_addr, ea);
    chk("R6 final len", cur_len, 0);
    cpu_halted = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 idle_req", idle_req, 0);
    chk("R1 bus_own", bus_own, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes", {mem_rd, mem_wr, per_ack}, 0);
    chk("R1 flags", {done_flag, abort_flag}, 0);
  endtask

  task automatic t_send(input logic [15:0] a, input logic [15:0] l);
    logic [7:0] got;
    int acks0;
    acks0 = n_ack;
    start_xfer(1'b1, a, l);
    chk("R2 addr loaded", cur_addr, a);
    grant();
    for (int i = 0; i < l; i++) begin
      do_byte(8'h00, got);
      chk("R4 send data", got, mem[8'(a + 16'(i))]);
    end
    chk("R10 ack count", n_ack - acks0, l);
    finish_chk(a + l);
  endtask

  task automatic t_recv(input logic [15:0] a, input logic [15:0] l);
    logic [7:0] got;
    int rd0;
    rd0 = n_strb;
    start_xfer(1'b0, a, l);
    grant();
    for (int i = 0; i < l; i++) do_byte(8'hA0 + 8'(i), got);
    for (int i = 0; i < l; i++)
      chk("R5 recv stored", mem[8'(a + 16'(i))], 8'hA0 + 8'(i));
    chk("R5 one strobe per byte", n_strb - rd0, l);
    finish_chk(a + l);
  endtask

  task automatic t_zero();
    int s0;
    s0 = n_strb;
    start_xfer(1'b1, 16'h0033, 16'h0000);
    chk("R8 done at once", done_flag, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R8 no idle_req", idle_req, 0);
      @(negedge clk);
    end
    chk("R8 no strobes", n_strb - s0, 0);
    chk("R8 no busy", busy, 0);
  endtask

  task automatic t_abort_and_restart();
    logic [7:0] got;
    logic [15:0] ra, rl;
    start_xfer(1'b1, 16'h0080, 16'd5);
    grant();
    do_byte(8'h00, got);
    do_byte(8'h00, got);
    // R10: no request, no byte
    repeat (5) @(negedge clk);
    chk("R10 idle without req", cur_len, 3);
    irq_pend = 8'h02; irq_en = 8'h02;
    @(negedge clk);
    chk("R9 abort flag", abort_flag, 1);
    chk("R9 done clear", done_flag, 0);
    chk("R9 released", {busy, idle_req, bus_own}, 0);
    chk("R9 addr kept", cur_addr, 16'h0082);
    chk("R9 len kept", cur_len, 16'd3);
    irq_pend = 8'h00; irq_en = 8'h00;
    cpu_halted = 1'b0;
    ra = cur_addr; rl = cur_len;
    start_xfer(1'b1, ra, rl);
    chk("R12 abort cleared", abort_flag, 0);
    grant();
    do_byte(8'h00, got);
    chk("R4 resumed data", got, mem[8'h82]);
    irq_pend = 8'h04; irq_en = 8'h02;
    do_byte(8'h00, got);
    do_byte(8'h00, got);
    chk("R9 masked ignored", abort_flag, 0);
    irq_pend = 8'h00; irq_en = 8'h00;
    finish_chk(16'h0085);
  endtask

  task automatic t_busy_start();
    logic [7:0] got;
    start_xfer(1'b1, 16'h0020, 16'd2);
    @(negedge clk);
    cfg_addr = 16'h0099; cfg_len = 16'd9; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk("R11 addr unchanged", cur_addr, 16'h0020);
    chk("R11 len unchanged", cur_len, 16'd2);
    cpu_halted = 1'b1;
    @(negedge clk);
    do_byte(8'h00, got);
    chk("R11 data from first addr", got, mem[8'h20]);
    do_byte(8'h00, got);
    finish_chk(16'h0022);
    start_xfer(1'b1, 16'h0001, 16'd0);
    chk("R12 done reset then set", done_flag, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    cfg_start = 0; cfg_dir = 0; cfg_addr = 0; cfg_len = 0;
    irq_pend = 0; irq_en = 0; cpu_halted = 0;
    per_req = 0; per_rdata = 0; rst_n = 0;
    t_reset();
    t_send(16'h0010, 16'd4);
    t_recv(16'h0040, 16'd3);
    t_send(16'h00FE, 16'd3);   // R6 carry into high byte
    t_recv(16'hFFFF, 16'd2);   // R6 full wrap
    t_zero();
    t_abort_and_restart();
    t_busy_start();
    chk("R3 strobes only with bus", n_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule